// File: doc/BRIEF.md
# Imprecise Abort Pending and Mask Controller

This block holds asynchronous data-abort events, such as an error that a bus reports for a buffered write long after the storing instruction has retired. Such an event is caught in a pending flag rather than acted on at once. The flag stays set until the exception-entry logic acknowledges the abort. The block also owns the abort mask bit of the current status word. Reset, the acknowledge and entry into the modes that must not be disturbed all force that bit to 1. Software writes to the bit pass through a security filter.

A data-abort request goes to the exception logic only while an abort is pending and the mask is clear. Precise aborts, such as those raised by watchpoints, arrive tagged as precise and never reach the pending path. All pins are plain control and status signals. No pin carries streaming data, so the block has no valid/ready interface and applies no back-pressure. Every input is sampled on each rising clock edge, and every output is a register.

Top module: `imprecise_abort_ctrl`

## Requirements
- R1: During and right after a synchronous reset, `mask_a` is 1, `pending` is 0 and `abort_req` is 0.
- R2: An edge with `err_valid`=1 and `err_precise`=0 sets `pending` after that edge, whatever the state of the mask.
- R3: An error flagged with `err_precise`=1 (a watchpoint abort) never changes `pending`.
- R4: While `mask_a` is 1, a pending abort is kept without loss until an acknowledge arrives. Changes of the mask never clear it.
- R5: `abort_ack` clears `pending` after the edge. If an imprecise error arrives at the same edge, `pending` stays 1.
- R6: `abort_req` is 1 exactly when `pending` is 1 and `mask_a` is 0, in the same cycle as those two outputs.
- R7: `mode_entry` with `mode_target` FIQ (5'b10001), IRQ (5'b10010) or Abort (5'b10111) sets `mask_a` to 1 after the edge. Entry into User (5'b10000), Supervisor (5'b10011) or Monitor (5'b10110) leaves the mask unchanged.
- R8: `abort_ack` sets `mask_a` to 1 at the same edge at which it clears the pending flag.
- R9: In the secure state (`ns_state`=0), `mask_wr_en` loads `mask_wr_val` into `mask_a` after the edge, whatever the value of `ns_mask_wr_ok`.
- R10: In the non-secure state with `ns_mask_wr_ok`=0, neither a direct write nor a restore changes `mask_a`. With `ns_mask_wr_ok`=1, both take effect.
- R11: `restore_en` loads `restore_val` (the saved-status mask bit) into `mask_a` under the same filter. If a direct write comes at the same edge, the direct write wins.
- R12: Priority for `mask_a` is reset first, then mode-entry set or acknowledge, then software writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_valid | input | 1 | Abort error event from the memory system |
| err_precise | input | 1 | The event is precise (watchpoint), so it is not held as pending |
| mode_entry | input | 1 | Exception or mode entry strobe |
| mode_target | input | 5 | Mode being entered, qualified by `mode_entry` |
| ns_state | input | 1 | The processor is in the non-secure state |
| ns_mask_wr_ok | input | 1 | Secure-configuration permission for non-secure mask writes |
| mask_wr_en | input | 1 | Software write to the current mask bit |
| mask_wr_val | input | 1 | Value for the direct write |
| restore_en | input | 1 | Restore of the saved status into the current status |
| restore_val | input | 1 | Mask bit held in the saved status |
| abort_ack | input | 1 | The exception logic is taking the data abort |
| mask_a | output | 1 | Current abort mask bit |
| pending | output | 1 | An imprecise abort is pending |
| abort_req | output | 1 | Request to take a data-abort exception |

## Verification
Every result is due one clock edge after its stimulus. The inputs driven before edge n show up on `mask_a`, `pending` and `abort_req` just after edge n, because all three outputs are registers with no further delay. The bench changes inputs on the falling edge and samples the outputs one time unit after the next rising edge. A bench model advances at that same edge and is compared with the outputs every cycle. Directed sequences check the held-while-masked case, the acknowledge that meets a new error at the same edge, and the security filter, each at the single cycle where its effect is due.

// File: rtl/iab_pkg.sv
package iab_pkg;
  localparam int MODE_W = 5;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_MON = 5'b10110,
    MODE_ABT = 5'b10111
  } proc_mode_e;

  localparam int N_MASKING = 3;
  localparam logic [MODE_W-1:0] MASKING_MODES [N_MASKING] = '{MODE_FIQ, MODE_IRQ, MODE_ABT};

  typedef struct packed {
    logic wr_en;
    logic wr_val;
  } mask_wr_t;
endpackage

// File: rtl/iab_pend_latch.sv
module iab_pend_latch (
  input  logic clk,
  input  logic rst,
  input  logic err_valid,
  input  logic err_precise,
  input  logic ack,
  output logic pend_d,
  output logic pend_q
);
  logic capture;

  assign capture = err_valid & ~err_precise;

  always_comb begin
    if (capture)   pend_d = 1'b1;
    else if (ack)  pend_d = 1'b0;
    else           pend_d = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_d;
  end

  // R2: an imprecise error always leaves the flag set
  a_r2_err_sets: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !err_precise) |=> pend_q);
  // R3: a precise error alone never creates a pending abort
  a_r3_precise_ignored: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_precise && !pend_q) |=> !pend_q);
  // R4: only an acknowledge can clear the flag
  a_r4_held_until_ack: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !ack) |=> pend_q);
endmodule

// File: rtl/iab_wr_filter.sv
module iab_wr_filter
  import iab_pkg::*;
(
  input  logic     ns_state,
  input  logic     ns_mask_wr_ok,
  input  logic     mask_wr_en,
  input  logic     mask_wr_val,
  input  logic     restore_en,
  input  logic     restore_val,
  output mask_wr_t wr_out
);
  logic permit;

  assign permit = ~ns_state | ns_mask_wr_ok;

  always_comb begin
    wr_out = '0;
    if (permit) begin
      if (mask_wr_en) begin
        wr_out.wr_en  = 1'b1;
        wr_out.wr_val = mask_wr_val;
      end else if (restore_en) begin
        wr_out.wr_en  = 1'b1;
        wr_out.wr_val = restore_val;
      end
    end
  end
endmodule

// File: rtl/iab_mask_ctl.sv
module iab_mask_ctl
  import iab_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_entry,
  input  logic [MODE_W-1:0] mode_target,
  input  logic              ack,
  input  mask_wr_t          wr_in,
  output logic              mask_d,
  output logic              mask_q
);
  logic [N_MASKING-1:0] hit;
  logic                 force_set;

  for (genvar g = 0; g < N_MASKING; g++) begin : g_mode_match
    assign hit[g] = (mode_target == MASKING_MODES[g]);
  end

  assign force_set = ack | (mode_entry & (|hit));

  always_comb begin
    if (force_set)         mask_d = 1'b1;
    else if (wr_in.wr_en)  mask_d = wr_in.wr_val;
    else                   mask_d = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= 1'b1;
    else     mask_q <= mask_d;
  end

  // R7: entry into a masking mode sets the bit
  a_r7_entry_sets: assert property (@(posedge clk) disable iff (rst)
    (mode_entry && (mode_target == MODE_FIQ || mode_target == MODE_IRQ ||
                    mode_target == MODE_ABT)) |=> mask_q);
  // R8: acknowledge sets the bit
  a_r8_ack_masks: assert property (@(posedge clk) disable iff (rst)
    ack |=> mask_q);
  // R10: with no permitted write and no forced set the bit holds
  a_r10_no_write_stable: assert property (@(posedge clk) disable iff (rst)
    (!wr_in.wr_en && !ack && !mode_entry) |=> $stable(mask_q));
endmodule

// File: rtl/iab_req_stage.sv
module iab_req_stage (
  input  logic clk,
  input  logic rst,
  input  logic pend_d,
  input  logic mask_d,
  output logic req_q
);
  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= pend_d & ~mask_d;
  end
endmodule

// File: rtl/imprecise_abort_ctrl.sv
module imprecise_abort_ctrl
  import iab_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              err_valid,
  input  logic              err_precise,
  input  logic              mode_entry,
  input  logic [MODE_W-1:0] mode_target,
  input  logic              ns_state,
  input  logic              ns_mask_wr_ok,
  input  logic              mask_wr_en,
  input  logic              mask_wr_val,
  input  logic              restore_en,
  input  logic              restore_val,
  input  logic              abort_ack,
  output logic              mask_a,
  output logic              pending,
  output logic              abort_req
);
  logic     pend_d, mask_d;
  mask_wr_t wr_sel;

  iab_pend_latch u_pend (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_precise(err_precise),
    .ack(abort_ack), .pend_d(pend_d), .pend_q(pending)
  );

  iab_wr_filter u_filt (
    .ns_state(ns_state), .ns_mask_wr_ok(ns_mask_wr_ok),
    .mask_wr_en(mask_wr_en), .mask_wr_val(mask_wr_val),
    .restore_en(restore_en), .restore_val(restore_val), .wr_out(wr_sel)
  );

  iab_mask_ctl u_mask (
    .clk(clk), .rst(rst), .mode_entry(mode_entry), .mode_target(mode_target),
    .ack(abort_ack), .wr_in(wr_sel), .mask_d(mask_d), .mask_q(mask_a)
  );

  iab_req_stage u_req (
    .clk(clk), .rst(rst), .pend_d(pend_d), .mask_d(mask_d), .req_q(abort_req)
  );

  // R6: the request agrees with the two registered state bits
  a_r6_req_consistent: assert property (@(posedge clk) disable iff (rst)
    abort_req == (pending && !mask_a));
  // R10: a blocked non-secure write leaves the mask alone
  a_r10_ns_blocked: assert property (@(posedge clk) disable iff (rst)
    (ns_state && !ns_mask_wr_ok && !abort_ack && !mode_entry) |=> $stable(mask_a));
  // R1: one cycle after reset the block is masked and idle
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (mask_a && !pending && !abort_req));
endmodule

// File: tb/test_imprecise_abort_ctrl.sv
module test_imprecise_abort_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       err_valid, err_precise, mode_entry, ns_state, ns_mask_wr_ok;
  logic       mask_wr_en, mask_wr_val, restore_en, restore_val, abort_ack;
  logic [4:0] mode_target;
  logic       mask_a, pending, abort_req;

  int checks = 0;
  int errors = 0;
  logic m_mask, m_pend;

  always #2.5 clk = ~clk;

  imprecise_abort_ctrl i_imprecise_abort_ctrl (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_precise(err_precise),
    .mode_entry(mode_entry), .mode_target(mode_target), .ns_state(ns_state),
    .ns_mask_wr_ok(ns_mask_wr_ok), .mask_wr_en(mask_wr_en), .mask_wr_val(mask_wr_val),
    .restore_en(restore_en), .restore_val(restore_val), .abort_ack(abort_ack),
    .mask_a(mask_a), .pending(pending), .abort_req(abort_req)
  );

  function automatic logic f_mask_next(logic cur);
    logic permit;
    permit = !ns_state || ns_mask_wr_ok;
    if (rst) return 1'b1;
    if (abort_ack) return 1'b1;
    if (mode_entry && (mode_target == 5'b10001 || mode_target == 5'b10010 ||
                       mode_target == 5'b10111)) return 1'b1;
    if (permit && mask_wr_en) return mask_wr_val;
    if (permit && restore_en) return restore_val;
    return cur;
  endfunction

  function automatic logic f_pend_next(logic cur);
    if (rst) return 1'b0;
    if (err_valid && !err_precise) return 1'b1;
    if (abort_ack) return 1'b0;
    return cur;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    err_valid = 0; err_precise = 0; mode_entry = 0; mode_target = 5'b10000;
    mask_wr_en = 0; mask_wr_val = 0; restore_en = 0; restore_val = 0; abort_ack = 0;
  endtask

  // apply inputs already driven, step one edge, check all outputs against the model
  task automatic step(string tag);
    m_mask = f_mask_next(m_mask);
    m_pend = f_pend_next(m_pend);
    @(posedge clk); #1;
    chk({tag, " mask"}, mask_a, m_mask);
    chk({tag, " pend"}, pending, m_pend);
    chk("R6 req", abort_req, m_pend && !m_mask);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); ns_state = 0; ns_mask_wr_ok = 0; rst = 1;
    m_mask = 1; m_pend = 0;
    @(negedge clk);
    step("R1 reset");
    rst = 0;
    @(negedge clk);

    // R2 / R4: error while masked is held
    err_valid = 1; step("R2 capture");
    for (int i = 0; i < 5; i++) step("R4 hold");
    chk("R4 no req while masked", abort_req, 1'b0);
    // R9: secure write clears mask, request rises
    mask_wr_en = 1; mask_wr_val = 0; step("R9 secure clear");
    chk("R6 req raised", abort_req, 1'b1);
    // R5/R8: ack with simultaneous error keeps pending, sets mask
    abort_ack = 1; err_valid = 1; step("R5 ack+err");
    chk("R5 pend kept", pending, 1'b1);
    chk("R8 mask set", mask_a, 1'b1);
    abort_ack = 1; step("R5 ack clears");
    chk("R5 pend cleared", pending, 1'b0);
    // R3: precise error ignored
    err_valid = 1; err_precise = 1; step("R3 precise");
    chk("R3 no pend", pending, 1'b0);
    // R10: nonsecure blocked
    mask_wr_en = 1; mask_wr_val = 0; ns_state = 1; ns_mask_wr_ok = 0; step("R10 blocked");
    chk("R10 blocked stays 1", mask_a, 1'b1);
    restore_en = 1; restore_val = 0; step("R10 restore blocked");
    chk("R10 restore blocked stays 1", mask_a, 1'b1);
    // R11: permitted restore, then direct write wins
    ns_mask_wr_ok = 1; restore_en = 1; restore_val = 0; step("R11 restore");
    chk("R11 restore applied", mask_a, 1'b0);
    restore_en = 1; restore_val = 0; mask_wr_en = 1; mask_wr_val = 1; step("R11 direct wins");
    chk("R11 direct wins", mask_a, 1'b1);
    // R9: secure write ignores permission bit
    ns_state = 0; ns_mask_wr_ok = 0; mask_wr_en = 1; mask_wr_val = 0; step("R9 secure");
    chk("R9 secure write", mask_a, 1'b0);
    // R7: non-masking modes leave it clear, masking modes set it
    mode_entry = 1; mode_target = 5'b10011; step("R7 svc");
    chk("R7 svc no set", mask_a, 1'b0);
    mode_entry = 1; mode_target = 5'b10110; step("R7 mon");
    chk("R7 mon no set", mask_a, 1'b0);
    mode_entry = 1; mode_target = 5'b10010; step("R7 irq");
    chk("R7 irq sets", mask_a, 1'b1);
    mask_wr_en = 1; mask_wr_val = 0; step("R9 clear");
    // R12: entry beats software write
    mode_entry = 1; mode_target = 5'b10001; mask_wr_en = 1; mask_wr_val = 0; step("R12 prio");
    chk("R12 entry wins", mask_a, 1'b1);

    // random phase against the model
    for (int n = 0; n < 3000; n++) begin
      err_valid     = ($urandom % 8) == 0;
      err_precise   = ($urandom % 3) == 0;
      mode_entry    = ($urandom % 6) == 0;
      case ($urandom % 6)
        0: mode_target = 5'b10000; 1: mode_target = 5'b10001;
        2: mode_target = 5'b10010; 3: mode_target = 5'b10011;
        4: mode_target = 5'b10110; default: mode_target = 5'b10111;
      endcase
      ns_state      = $urandom % 2;
      ns_mask_wr_ok = $urandom % 2;
      mask_wr_en    = ($urandom % 4) == 0;
      mask_wr_val   = ($urandom % 3) == 0;
      restore_en    = ($urandom % 5) == 0;
      restore_val   = ($urandom % 3) == 0;
      abort_ack     = ($urandom % 7) == 0;
      rst           = ($urandom % 500) == 0;
      step("R12 random");
      rst = 0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule